// File: doc/BRIEF.md
# Hierarchical Page Table Walker

This block converts a virtual address into a physical address by reading a tree of page tables that lives in memory. A requester, typically a translation cache that has just missed, presents the virtual address together with the physical address of the top-level table. It holds that request until the walker answers. The walker then fetches one table entry per level over a simple read port, and each fetched entry supplies the base of the table below it. It ends with either a physical address and the permission bits of the final entry, or a fault.

The virtual address is made of a page offset in its low `PAGE_BITS` bits and, above it, `LEVELS` equal index fields of `IDX_W` bits each. The most significant field selects the entry in the top-level table. Each entry is 8 bytes wide. Bit 0 is the valid flag. Bits 4:1 are the permissions: bit 1 read, bit 2 write, bit 3 execute, bit 4 supervisor. Bits `PA_W-1:PAGE_BITS` hold a frame number, which is either the page-aligned base of the next table or the final physical page. A cleared valid flag at any level stops the walk with a fault. The page offset passes through unchanged.

Top module: `pt_walker`

## Requirements
- R1: After reset, `done`, `fault` and `mem_rd_valid` are low.
- R2: The first read of a walk goes to `req_ptbr + 8*idx`, where idx is the most significant index field of `req_va`.
- R3: Each later read goes to `(frame << PAGE_BITS) + 8*idx`, where frame is bits `PA_W-1:PAGE_BITS` of the previous entry and idx is the next lower index field.
- R4: Only one read is outstanding at a time. `mem_rd_valid` is high for exactly one cycle, and the next read is not issued until `mem_rsp_valid` has returned data.
- R5: When the entry at the last level is valid, the walk makes exactly `LEVELS` reads. `done` then pulses and `pa_out` equals `{frame of last entry, req_va[PAGE_BITS-1:0]}`.
- R6: With `done`, `perm_out` equals bits 4:1 of the last-level entry.
- R7: An entry with bit 0 clear, at any level, ends the walk at once. No further read is issued, `fault` pulses, and `pa_out` and `perm_out` are zero.
- R8: `done` and `fault` are never high together, and each stays high for a single cycle.
- R9: While no walk is running and `req_valid` is low, no read is issued and no result pulses. A request held after a result starts a fresh walk from the top level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request, held until `done` or `fault` |
| req_va | input | VA_W | Virtual address to translate |
| req_ptbr | input | PA_W | Physical address of the top-level table |
| mem_rd_valid | output | 1 | Single-cycle entry read strobe |
| mem_rd_addr | output | PA_W | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data is present |
| mem_rsp_data | input | PTE_W | Entry read from memory |
| done | output | 1 | One-cycle pulse: translation succeeded |
| fault | output | 1 | One-cycle pulse: invalid entry met |
| pa_out | output | PA_W | Physical address, valid with `done` |
| perm_out | output | 4 | Permissions of the final entry, valid with `done` |

## Verification
The assertions assume three things about the inputs. The requester keeps `req_va` and `req_ptbr` unchanged from the start of a request until its result pulse. The table base is 8-byte aligned. The memory returns exactly one response per read, and only after that read. The bench meets these assumptions as follows. It changes the request only between walks. It uses top-level tables at page-aligned frames. Its memory model answers each strobe once, after a random delay of zero to three cycles. Random walks over two prepared two-level trees are mixed with directed addresses that hit a top-level invalid entry, a second-level invalid entry and a known mapping.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE,
    ST_FAULT
  } ptw_state_e;

  localparam int ENTRY_SHIFT = 3;  // 8-byte entries
  localparam int VALID_BIT   = 0;
  localparam int PERM_LSB    = 1;
  localparam int PERM_W      = 4;
endpackage

// File: rtl/ptw_index_sel.sv
module ptw_index_sel #(
  parameter int PAGE_BITS = 12,
  parameter int IDX_W     = 9,
  parameter int LEVELS    = 4,
  parameter int PA_W      = 52,
  parameter int LVL_W     = 2,
  parameter int VA_W      = PAGE_BITS + LEVELS * IDX_W
) (
  input  logic [VA_W-1:0]  va,
  input  logic [LVL_W-1:0] level,
  input  logic [PA_W-1:0]  table_base,
  output logic [PA_W-1:0]  entry_addr
);
  import ptw_pkg::*;

  localparam int PAD_W = PA_W - IDX_W - ENTRY_SHIFT;

  logic [IDX_W-1:0] field [LEVELS];
  logic [IDX_W-1:0] idx;

  // level 0 takes the most significant field
  for (genvar g = 0; g < LEVELS; g++) begin : g_field
    assign field[g] = va[PAGE_BITS + (LEVELS-1-g)*IDX_W +: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (level == LVL_W'(i)) idx = field[i];
    end
  end

  assign entry_addr = table_base + {{PAD_W{1'b0}}, idx, {ENTRY_SHIFT{1'b0}}};
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
  parameter int PTE_W     = 64,
  parameter int PA_W      = 52,
  parameter int PAGE_BITS = 12
) (
  input  logic [PTE_W-1:0]          pte,
  output logic                      valid,
  output logic [3:0]                perm,
  output logic [PA_W-PAGE_BITS-1:0] frame
);
  import ptw_pkg::*;

  assign valid = pte[VALID_BIT];
  assign perm  = pte[PERM_LSB +: PERM_W];
  assign frame = pte[PA_W-1:PAGE_BITS];
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int PAGE_BITS = 12,
  parameter int IDX_W     = 9,
  parameter int LEVELS    = 4,
  parameter int PA_W      = 52,
  parameter int PTE_W     = 64,
  parameter int VA_W      = PAGE_BITS + LEVELS * IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_va,
  input  logic [PA_W-1:0]  req_ptbr,
  output logic             mem_rd_valid,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             done,
  output logic             fault,
  output logic [PA_W-1:0]  pa_out,
  output logic [3:0]       perm_out
);
  import ptw_pkg::*;

  localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int FRAME_W = PA_W - PAGE_BITS;
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  ptw_state_e       state_q;
  logic [LVL_W-1:0] level_q;
  logic [VA_W-1:0]  va_q;
  logic [PA_W-1:0]  base_q;
  logic             rd_valid_q;
  logic [PA_W-1:0]  rd_addr_q;
  logic             done_q, fault_q;
  logic [PA_W-1:0]  pa_q;
  logic [3:0]       perm_q;

  logic [PA_W-1:0]    entry_addr;
  logic               pte_valid;
  logic [3:0]         pte_perm;
  logic [FRAME_W-1:0] pte_frame;

  ptw_index_sel #(
    .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W), .LEVELS(LEVELS),
    .PA_W(PA_W), .LVL_W(LVL_W), .VA_W(VA_W)
  ) u_idx (
    .va(va_q), .level(level_q), .table_base(base_q), .entry_addr(entry_addr)
  );

  ptw_pte_decode #(
    .PTE_W(PTE_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)
  ) u_dec (
    .pte(mem_rsp_data), .valid(pte_valid), .perm(pte_perm), .frame(pte_frame)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      level_q    <= '0;
      va_q       <= '0;
      base_q     <= '0;
      rd_valid_q <= 1'b0;
      rd_addr_q  <= '0;
      done_q     <= 1'b0;
      fault_q    <= 1'b0;
      pa_q       <= '0;
      perm_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            va_q    <= req_va;
            base_q  <= req_ptbr;
            level_q <= '0;
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          rd_valid_q <= 1'b1;
          rd_addr_q  <= entry_addr;
          state_q    <= ST_WAIT;
        end
        ST_WAIT: begin
          rd_valid_q <= 1'b0;
          if (mem_rsp_valid) begin
            if (!pte_valid) begin
              fault_q <= 1'b1;
              pa_q    <= '0;
              perm_q  <= '0;
              state_q <= ST_FAULT;
            end else if (level_q == LAST_LVL) begin
              done_q  <= 1'b1;
              pa_q    <= {pte_frame, va_q[PAGE_BITS-1:0]};
              perm_q  <= pte_perm;
              state_q <= ST_DONE;
            end else begin
              base_q  <= {pte_frame, {PAGE_BITS{1'b0}}};
              level_q <= level_q + 1'b1;
              state_q <= ST_ISSUE;
            end
          end
        end
        default: begin  // ST_DONE, ST_FAULT
          done_q  <= 1'b0;
          fault_q <= 1'b0;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign mem_rd_valid = rd_valid_q;
  assign mem_rd_addr  = rd_addr_q;
  assign done         = done_q;
  assign fault        = fault_q;
  assign pa_out       = pa_q;
  assign perm_out     = perm_q;

  // Assertions
  initial AST_GEOMETRY: assert (IDX_W + ENTRY_SHIFT <= PAGE_BITS && PTE_W >= PA_W); // R3

  AST_READ_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |=> !mem_rd_valid); // R4
  AST_NO_READ_WHILE_WAITING: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && !mem_rsp_valid) |=> !mem_rd_valid); // R4
  AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(done && fault)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (rst)
    fault |=> !fault); // R8
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
    done |-> pa_out[PAGE_BITS-1:0] == req_va[PAGE_BITS-1:0]); // R5
  AST_FAULT_ZEROES: assert property (@(posedge clk) disable iff (rst)
    fault |-> (pa_out == '0 && perm_out == '0)); // R7
  AST_NO_READ_AFTER_FAULT: assert property (@(posedge clk) disable iff (rst)
    fault |-> !mem_rd_valid); // R7
  AST_ENTRY_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && req_ptbr[ENTRY_SHIFT-1:0] == '0) |-> mem_rd_addr[ENTRY_SHIFT-1:0] == '0); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !req_valid) |=> (!mem_rd_valid && !done && !fault)); // R9
endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;
  localparam int PAGE_BITS = 12;
  localparam int IDX_W     = 9;
  localparam int LEVELS    = 2;
  localparam int PA_W      = 32;
  localparam int PTE_W     = 64;
  localparam int VA_W      = PAGE_BITS + LEVELS * IDX_W;
  localparam int MEM_WORDS = 4096;  // 8 frames of 4 KB

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_valid = 1'b0;
  logic [VA_W-1:0]  req_va = '0;
  logic [PA_W-1:0]  req_ptbr = '0;
  logic             mem_rd_valid;
  logic [PA_W-1:0]  mem_rd_addr;
  logic             mem_rsp_valid = 1'b0;
  logic [PTE_W-1:0] mem_rsp_data = '0;
  logic             done, fault;
  logic [PA_W-1:0]  pa_out;
  logic [3:0]       perm_out;

  always #2 clk = ~clk;  // 250 MHz

  pt_walker #(
    .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W), .LEVELS(LEVELS),
    .PA_W(PA_W), .PTE_W(PTE_W)
  ) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
    .req_ptbr(req_ptbr), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .fault(fault), .pa_out(pa_out), .perm_out(perm_out)
  );

  logic [PTE_W-1:0] mem [MEM_WORDS];
  int errors = 0;
  int checks = 0;
  int rd_cnt = 0;
  logic [PA_W-1:0] rd_log [4];
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [PTE_W-1:0] make_pte(input bit v, input logic [3:0] p,
                                                 input logic [19:0] frame);
    logic [PTE_W-1:0] e;
    e = {$urandom, $urandom};
    e[31:12] = frame;
    e[4:1]   = p;
    e[0]     = v;
    return e;
  endfunction

  // Memory responder: one answer per strobe after 0..3 idle cycles
  initial begin
    forever begin
      @(negedge clk);
      if (mem_rd_valid) begin
        logic [PA_W-1:0] a;
        int lat;
        a = mem_rd_addr;
        if (rd_cnt < 4) rd_log[rd_cnt] = a;
        rd_cnt++;
        lat = $urandom % 4;
        for (int k = 0; k < lat; k++) begin
          @(negedge clk);
          if (mem_rd_valid) chk(1'b0, "R4", "read issued before response", 1, 0);
        end
        if (lat == 0 || !mem_rd_valid) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = (a[PA_W-1:15] == '0) ? mem[a[14:3]] : '0;
          @(negedge clk);
          if (mem_rd_valid) chk(1'b0, "R4", "read issued before response", 1, 0);
          mem_rsp_valid = 1'b0;
          mem_rsp_data  = '0;
        end
      end
    end
  end

  task automatic walk(input logic [VA_W-1:0] va, input logic [PA_W-1:0] ptbr);
    logic [PTE_W-1:0] e1, e2;
    logic [PA_W-1:0]  a1, a2, exp_pa;
    logic [3:0]       exp_perm;
    bit               exp_fault;
    int               exp_reads, n;
    a1 = ptbr + {14'd0, va[29:21], 3'b000};
    e1 = mem[a1[14:3]];
    a2 = {e1[31:12], 12'd0} + {14'd0, va[20:12], 3'b000};
    e2 = mem[a2[14:3]];
    if (!e1[0]) begin
      exp_fault = 1'b1; exp_reads = 1; exp_pa = '0; exp_perm = '0;
    end else if (!e2[0]) begin
      exp_fault = 1'b1; exp_reads = 2; exp_pa = '0; exp_perm = '0;
    end else begin
      exp_fault = 1'b0; exp_reads = 2;
      exp_pa = {e2[31:12], va[11:0]}; exp_perm = e2[4:1];
    end
    rd_cnt = 0;
    req_va = va; req_ptbr = ptbr; req_valid = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (done && fault) chk(1'b0, "R8", "done and fault together", 1, 0);
    end while (!done && !fault && n < 100);
    req_valid = 1'b0;
    chk(fault == exp_fault, "R7", "fault flag", fault, exp_fault);
    chk(done == !exp_fault, "R5", "done flag", done, !exp_fault);
    chk(rd_cnt == exp_reads, exp_fault ? "R7" : "R5", "read count", rd_cnt, exp_reads);
    chk(rd_log[0] == a1, "R2", "first read address", rd_log[0], a1);
    if (exp_reads > 1) chk(rd_log[1] == a2, "R3", "second read address", rd_log[1], a2);
    chk(pa_out == exp_pa, exp_fault ? "R7" : "R5", "pa_out", pa_out, exp_pa);
    chk(perm_out == exp_perm, exp_fault ? "R7" : "R6", "perm_out", perm_out, exp_perm);
    @(negedge clk);
    chk(!done && !fault, "R8", "result pulse width", {done, fault}, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "R4", "watchdog expired", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    // top tables at frames 0 and 7, second-level tables at frames 1..6
    for (int i = 0; i < 512; i++) begin
      mem[i]           = make_pte(($urandom % 10) < 7, 4'($urandom), 20'(1 + $urandom % 6));
      mem[7*512 + i]   = make_pte(($urandom % 10) < 7, 4'($urandom), 20'(1 + $urandom % 6));
    end
    for (int f = 1; f <= 6; f++)
      for (int i = 0; i < 512; i++)
        mem[f*512 + i] = make_pte(($urandom % 4) != 0, 4'($urandom), 20'($urandom));
    // directed entries
    mem[5]           = make_pte(1'b0, 4'hF, 20'h00002);
    mem[6]           = make_pte(1'b1, 4'h0, 20'h00002);
    mem[2*512 + 7]   = make_pte(1'b0, 4'hF, 20'h12345);
    mem[2*512 + 8]   = make_pte(1'b1, 4'b1010, 20'hABCDE);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !fault && !mem_rd_valid, "R1", "reset state",
        {done, fault, mem_rd_valid}, 0);

    // R9: idle with no request stays quiet
    rd_cnt = 0;
    repeat (6) @(negedge clk);
    chk(rd_cnt == 0 && !done && !fault, "R9", "idle activity", rd_cnt, 0);

    walk({9'd6, 9'd8, 12'h5A3}, 32'h0);   // R5 R6 known mapping
    walk({9'd5, 9'd0, 12'h001}, 32'h0);   // R7 top-level invalid
    walk({9'd6, 9'd7, 12'hFFF}, 32'h0);   // R7 second-level invalid
    walk({9'd6, 9'd8, 12'h000}, 32'h0);   // offset boundary
    walk({9'd6, 9'd8, 12'hFFF}, 32'h0);

    // R9: request held across a result starts a fresh walk
    rd_cnt = 0;
    req_va = {9'd6, 9'd8, 12'h010}; req_ptbr = '0; req_valid = 1'b1;
    while (!done && !fault) @(negedge clk);
    rd_cnt = 0;
    while (!done && !fault) @(negedge clk);  // no-op: pulse still high
    @(negedge clk);
    while (!done && !fault) @(negedge clk);
    req_valid = 1'b0;
    chk(rd_cnt == 2 && rd_log[0] == {14'd0, 9'd6, 3'b000}, "R9",
        "re-walk from top level", rd_log[0], {14'd0, 9'd6, 3'b000});
    repeat (2) @(negedge clk);

    for (int t = 0; t < 300; t++) begin
      walk(VA_W'({$urandom, $urandom}), ($urandom % 2) ? 32'h7000 : 32'h0);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule